// File: doc/BRIEF.md
# Status Readout Serial Shift Interface

This block is the read side of a chip-enable-framed serial slave. A host controller drives a select line and a serial clock. While select is high and the read mode is chosen, the block returns a fixed status word on a data-out line, one bit per serial clock. The host serial lines are asynchronous to the block clock, so they are brought into the block clock domain before their edges are acted on. A separate decoder, outside this block, turns the host's data-in line into the `readout_sel` level.

The status word is 3 + `CNT_W` bits long. It holds three header bits followed by a gated event counter. The header bits are the levels of two I/O pins and a lock indication. The counter is part of this block. It counts single-cycle event pulses while an external window signal is high, it clears when the window opens, and it stops at all ones rather than wrapping.

Every field is frozen into a snapshot register in the cycle that select is seen rising with the read mode chosen. Inputs that change later in the frame do not reach the shifted bits.

Top module: `status_shift_readout`

## Requirements
- R1: `sdo_oe` is 1 only while a frame started with `readout_sel`=1 is open. It drops after `host_sel` goes low. A frame opened with `readout_sel`=0 keeps `sdo_oe` at 0. Whenever `sdo_oe` is 0, `sdo` is 0.
- R2: The bits leave in this order: `io_level[1]`, then `io_level[0]`, then `lock_ok`, then counter bit `CNT_W-1` down to counter bit 0.
- R3: An I/O bit reads 1 when the pin level is high and 0 when it is low.
- R4: The lock bit copies `lock_ok`. A value of 1 means locked or detection stopped, and 0 means unlocked.
- R5: All fields are sampled when the frame opens. Changes to the pins, the lock flag or the counter during the frame do not alter the shifted bits.
- R6: The first bit appears once select is seen high. Each later bit appears after a falling serial clock edge. A rising serial clock edge never changes `sdo`.
- R7: After every bit of the word has been shifted, further falling edges leave `sdo` at 0.
- R8: In the cycle `gate_en` rises, the counter loads the value of `meas_pulse` (0 or 1). On each later cycle with `gate_en` high, it adds 1 when `meas_pulse` is 1.
- R9: The counter holds at all ones instead of wrapping.
- R10: While `gate_en` is low, the counter holds its value and ignores `meas_pulse`.
- R11: Dropping select in the middle of a frame abandons it. The next frame starts again from `io_level[1]`.
- R12: After reset, `sdo` and `sdo_oe` are 0 and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host select (chip enable), asynchronous |
| host_sclk | input | 1 | Host serial clock, asynchronous |
| readout_sel | input | 1 | Read mode chosen by the input decoder |
| io_level | input | 2 | Present levels of the two I/O pins |
| lock_ok | input | 1 | Lock indication, 1 = locked or detection stopped |
| gate_en | input | 1 | Counting window |
| meas_pulse | input | 1 | One-cycle event pulse to be counted |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for `sdo` |

## Verification
The bench builds the block with `CNT_W` = 6, giving a 9-bit word and a counter ceiling of 63. With that ceiling, a sweep over every pulse count from 0 to 70 is short. The sweep covers every counter value, the stop at all ones and every combination of the three header bits. Each frame is read with slow host edges, so every bit can also be checked across the rising edge. The abort, mute and mid-frame change cases are then run on top of the sweep.

// File: rtl/status_rd_pkg.sv
package status_rd_pkg;

    localparam int HDR_BITS = 3;

    typedef enum logic [1:0] {
        FR_IDLE   = 2'd0,
        FR_SHIFT  = 2'd1,
        FR_IGNORE = 2'd2
    } frame_state_e;

    typedef struct packed {
        logic io2;
        logic io1;
        logic lock;
    } hdr_t;

    function automatic hdr_t make_hdr(input logic [1:0] io, input logic lk);
        hdr_t h;
        h.io2  = io[1];
        h.io1  = io[0];
        h.lock = lk;
        return h;
    endfunction

endpackage

// File: rtl/serial_sync.sv
module serial_sync #(
    parameter int STAGES = 2,
    parameter int N      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] prv
);

    for (genvar g = 0; g < N; g++) begin : g_ch
        logic [STAGES-1:0] chain;
        logic              last;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
                last  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
                last  <= chain[STAGES-1];
            end
        end

        assign lvl[g] = chain[STAGES-1];
        assign prv[g] = last;
    end

endmodule

// File: rtl/gated_counter.sv
module gated_counter #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         gate_en,
    input  logic         pulse,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic gate_q;
    logic gate_open;

    assign gate_open = gate_en & ~gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
            cnt    <= '0;
        end else begin
            gate_q <= gate_en;
            if (gate_open) begin
                cnt <= W'(pulse);
            end else if (gate_en && pulse && (cnt != CNT_MAX)) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/status_shifter.sv
module status_shifter
    import status_rd_pkg::*;
#(
    parameter  int CNT_W  = 20,
    localparam int WORD_W = CNT_W + HDR_BITS,
    localparam int PTR_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_lvl,
    input  logic              ce_prv,
    input  logic              sck_lvl,
    input  logic              sck_prv,
    input  logic              readout_sel,
    input  logic [1:0]        io_level,
    input  logic              lock_ok,
    input  logic [CNT_W-1:0]  cnt,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [WORD_W-1:0] snap,
    output logic [PTR_W-1:0]  ptr
);

    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(WORD_W);

    frame_state_e      state;
    logic              ce_rise;
    logic              sck_fall;
    logic [WORD_W-1:0] shifted;

    assign ce_rise  = ce_lvl & ~ce_prv;
    assign sck_fall = ~sck_lvl & sck_prv;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FR_IDLE;
            ptr   <= '0;
            snap  <= '0;
        end else begin
            case (state)
                FR_IDLE: begin
                    if (ce_rise) begin
                        ptr <= '0;
                        if (readout_sel) begin
                            state <= FR_SHIFT;
                            snap  <= {make_hdr(io_level, lock_ok), cnt};
                        end else begin
                            state <= FR_IGNORE;
                        end
                    end
                end
                FR_SHIFT: begin
                    if (!ce_lvl) begin
                        state <= FR_IDLE;
                        ptr   <= '0;
                    end else if (sck_fall && (ptr != PTR_END)) begin
                        ptr <= ptr + 1'b1;
                    end
                end
                FR_IGNORE: begin
                    if (!ce_lvl) state <= FR_IDLE;
                end
                default: state <= FR_IDLE;
            endcase
        end
    end

    assign shifted = snap << ptr;
    assign sdo_oe  = (state == FR_SHIFT);
    assign sdo     = sdo_oe && (ptr != PTR_END) ? shifted[WORD_W-1] : 1'b0;

endmodule

// File: rtl/status_shift_readout.sv
module status_shift_readout
    import status_rd_pkg::*;
#(
    parameter  int CNT_W       = 20,
    parameter  int SYNC_STAGES = 2,
    localparam int WORD_W      = CNT_W + HDR_BITS,
    localparam int PTR_W       = $clog2(WORD_W + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_sel,
    input  logic       host_sclk,
    input  logic       readout_sel,
    input  logic [1:0] io_level,
    input  logic       lock_ok,
    input  logic       gate_en,
    input  logic       meas_pulse,
    output logic       sdo,
    output logic       sdo_oe
);

    logic [1:0]        sync_lvl;
    logic [1:0]        sync_prv;
    logic [CNT_W-1:0]  cnt_w;
    logic [WORD_W-1:0] snap_w;
    logic [PTR_W-1:0]  ptr_w;

    serial_sync #(
        .STAGES (SYNC_STAGES),
        .N      (2)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .raw ({host_sclk, host_sel}),
        .lvl (sync_lvl),
        .prv (sync_prv)
    );

    gated_counter #(
        .W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .gate_en (gate_en),
        .pulse   (meas_pulse),
        .cnt     (cnt_w)
    );

    status_shifter #(
        .CNT_W (CNT_W)
    ) u_shift (
        .clk         (clk),
        .rst         (rst),
        .ce_lvl      (sync_lvl[0]),
        .ce_prv      (sync_prv[0]),
        .sck_lvl     (sync_lvl[1]),
        .sck_prv     (sync_prv[1]),
        .readout_sel (readout_sel),
        .io_level    (io_level),
        .lock_ok     (lock_ok),
        .cnt         (cnt_w),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe),
        .snap        (snap_w),
        .ptr         (ptr_w)
    );

endmodule

// File: rtl/status_shift_readout_chk.sv
module status_shift_readout_chk #(
    parameter  int CNT_W  = 20,
    localparam int WORD_W = CNT_W + 3,
    localparam int PTR_W  = $clog2(WORD_W + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              sdo,
    input logic              sdo_oe,
    input logic              ce_lvl,
    input logic              sck_lvl,
    input logic              sck_prv,
    input logic              gate_en,
    input logic [CNT_W-1:0]  cnt,
    input logic [WORD_W-1:0] snap,
    input logic [PTR_W-1:0]  ptr
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(WORD_W);

    logic sclk_fall;
    assign sclk_fall = ~sck_lvl & sck_prv;

    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe |-> !sdo);

    // R1
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && !ce_lvl) |=> !sdo_oe);

    // R5
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && ce_lvl) |=> $stable(snap));

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && ce_lvl && !sclk_fall) |=> $stable(ptr));

    // R7
    ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ptr <= PTR_END);

    // R7
    tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr == PTR_END) |-> !sdo);

    // R8
    gate_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_en && !$past(gate_en)) |=> (cnt <= CNT_W'(1)));

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && gate_en && $past(gate_en)) |=> (cnt == CNT_MAX));

    // R10
    closed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !gate_en |=> $stable(cnt));

endmodule

bind status_shift_readout status_shift_readout_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe),
    .ce_lvl  (sync_lvl[0]),
    .sck_lvl (sync_lvl[1]),
    .sck_prv (sync_prv[1]),
    .gate_en (gate_en),
    .cnt     (cnt_w),
    .snap    (snap_w),
    .ptr     (ptr_w)
);

// File: tb/status_shift_readout_test.sv
module status_shift_readout_test;

    localparam int CW   = 6;
    localparam int WW   = CW + 3;
    localparam int MAXV = (1 << CW) - 1;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       host_sel, host_sclk, readout_sel, lock_ok, gate_en, meas_pulse;
    logic [1:0] io_level;
    logic       sdo, sdo_oe;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    status_shift_readout #(.CNT_W(CW)) uut (
        .clk         (clk),
        .rst         (rst),
        .host_sel    (host_sel),
        .host_sclk   (host_sclk),
        .readout_sel (readout_sel),
        .io_level    (io_level),
        .lock_ok     (lock_ok),
        .gate_en     (gate_en),
        .meas_pulse  (meas_pulse),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one counting window of n pulses, then stray pulses with the gate closed (R10)
    task automatic run_window(input int n);
        @(negedge clk);
        gate_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            meas_pulse = 1'b1;
            @(negedge clk);
        end
        meas_pulse = 1'b0;
        @(negedge clk);
        gate_en = 1'b0;
        meas_pulse = 1'b1;
        wait_clk(3);
        meas_pulse = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_frame(input bit mutate, output logic [WW-1:0] got);
        host_sel = 1'b1;
        wait_clk(10);
        check("R1 oe in frame", 32'(sdo_oe), 32'd1);
        got[WW-1] = sdo;
        for (int i = 1; i < WW; i++) begin
            host_sclk = 1'b1;
            wait_clk(HALF);
            check("R6 rising edge", 32'(sdo), 32'(got[WW-i]));
            if (mutate && i == 3) begin
                io_level   = ~io_level;
                lock_ok    = ~lock_ok;
                gate_en    = 1'b1;
                meas_pulse = 1'b1;
            end
            host_sclk = 1'b0;
            wait_clk(HALF);
            got[WW-1-i] = sdo;
        end
        for (int k = 0; k < 3; k++) begin
            host_sclk = 1'b1;
            wait_clk(HALF);
            host_sclk = 1'b0;
            wait_clk(HALF);
            check("R7 tail", 32'(sdo), 32'd0);
        end
        host_sel = 1'b0;
        wait_clk(HALF);
        check("R1 oe after", 32'(sdo_oe), 32'd0);
        check("R1 sdo after", 32'(sdo), 32'd0);
        gate_en    = 1'b0;
        meas_pulse = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [WW-1:0] expect_word(input logic [1:0] io, input logic lk, input int c);
        return {io[1], io[0], lk, CW'(c)};
    endfunction

    initial begin
        logic [WW-1:0] got;
        int            expc;
        rst = 1'b1;
        host_sel = 0; host_sclk = 0; readout_sel = 1; lock_ok = 0;
        gate_en = 0; meas_pulse = 0; io_level = 2'b00;
        wait_clk(5);
        rst = 1'b0;
        @(negedge clk);
        check("R12 oe", 32'(sdo_oe), 32'd0);
        check("R12 sdo", 32'(sdo), 32'd0);

        io_level = 2'b10; lock_ok = 1'b1;
        read_frame(1'b0, got);
        check("R12 R2 first word", 32'(got), 32'(expect_word(2'b10, 1'b1, 0)));

        // sweep every count, header combinations follow the count (R2 R3 R4 R8 R9 R10)
        for (int n = 0; n <= MAXV + 7; n++) begin
            io_level = 2'(n);
            lock_ok  = n[2];
            run_window(n);
            read_frame(1'b0, got);
            expc = (n > MAXV) ? MAXV : n;
            check(n > MAXV ? "R9 saturate" : "R2 R3 R4 R8 R10 word",
                  32'(got), 32'(expect_word(2'(n), n[2], expc)));
        end

        // R1: frame opened without read mode stays silent
        run_window(21);
        readout_sel = 1'b0;
        host_sel = 1'b1;
        wait_clk(10);
        for (int i = 0; i < 4; i++) begin
            check("R1 muted oe", 32'(sdo_oe), 32'd0);
            check("R1 muted sdo", 32'(sdo), 32'd0);
            host_sclk = 1'b1; wait_clk(HALF);
            host_sclk = 1'b0; wait_clk(HALF);
        end
        host_sel = 1'b0;
        wait_clk(HALF);
        readout_sel = 1'b1;

        // R11: abandoned frame, next one restarts from the first bit
        io_level = 2'b01; lock_ok = 1'b0;
        host_sel = 1'b1;
        wait_clk(10);
        for (int i = 0; i < 4; i++) begin
            host_sclk = 1'b1; wait_clk(HALF);
            host_sclk = 1'b0; wait_clk(HALF);
        end
        host_sel = 1'b0;
        wait_clk(HALF);
        read_frame(1'b0, got);
        check("R11 restart", 32'(got), 32'(expect_word(2'b01, 1'b0, 21)));

        // R5: inputs and counter change mid-frame
        io_level = 2'b11; lock_ok = 1'b1;
        read_frame(1'b1, got);
        check("R5 snapshot", 32'(got), 32'(expect_word(2'b11, 1'b1, 21)));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        wait_clk(150000);
        fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule